// File: doc/BRIEF.md
# Exact-Match Lookup Table with Paired Data Store

This block is a lookup engine built from two arrays that share rows: a key array whose rows are compared against a search key, and a data array holding one word per row. A search compares the presented key with every stored key at once. Each row's comparison result acts directly as the row select of the data array. The block therefore returns the stored data word belonging to the matching key, and a hit flag, rather than a row address.

Rows are loaded through a write port that sets the key, the data word and a valid bit of one addressed row. A search is strobed for one cycle, and the hit flag and data word appear registered on the next clock. Only exact equality over all key bits counts as a match. When several valid rows hold the same key, the row with the lowest index supplies the data. When no row matches, the data output is zero.

Top module: `cam_lookup`

## Requirements
- R1: A row matches a search only when all KEY_W bits of its stored key equal the search key; a key that differs in any single bit from every valid stored key gives hit = 0.
- R2: When a search strobe (srchEn = 1) is sampled on a rising clock edge, hit and rdData show the result of that search from that edge on, one clock after the strobe, and rdData is the data word stored in the matching row.
- R3: A row whose valid bit is 0 never matches, so writing a row with wrValid = 0 removes its key from all later searches.
- R4: When more than one valid row matches, rdData is the data word of the matching row with the lowest index.
- R5: When a search finds no matching row, hit = 0 and rdData = 0.
- R6: A write sampled on a clock edge changes the result of searches strobed on later edges only; a search strobed on the same edge as a write sees the row contents from before that write.
- R7: On edges where srchEn = 0, hit and rdData keep their previous values whatever the search key does.
- R8: An active-low reset clears every valid bit and drives hit and rdData to 0.
- R9: Every row is compared in the same single evaluation, so a key held only in the highest-index row is found with the same one-cycle latency as one held in row 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the addressed row |
| wrAddr | input | $clog2(ROWS) | Row index written |
| wrKey | input | KEY_W | Key stored in the row |
| wrData | input | DATA_W | Data word stored in the row |
| wrValid | input | 1 | Valid bit stored in the row |
| srchEn | input | 1 | Search strobe |
| srchKey | input | KEY_W | Key searched for |
| hit | output | 1 | Registered: some valid row matched the last search |
| rdData | output | DATA_W | Registered: data word of the winning row, zero on a miss |

## Verification
The bench sweeps every key value of a small configuration after several loadings of the table, so a comparator that ignores a bit or a row that never drives its select shows up as a wrong hit or a wrong word. Duplicate keys are stacked across all rows and then removed one row at a time from the bottom, which catches a priority chain that favours the highest index or merges two rows' data. A write and a search on the same edge are checked to return the old contents, which a design that bypassed the write into the compare would get wrong. Outputs are watched with the strobe low and the key changing, and again after a second reset, which catches outputs that follow the comparator directly or valid bits that survive reset.

// File: rtl/cam_pkg.sv
package cam_pkg;
  typedef struct packed {
    logic wrStb;
    logic srchStb;
  } camCtrl_t;
endpackage

// File: rtl/cam_ctrl.sv
module cam_ctrl #(
  parameter int ROWS = 8,
  localparam int AW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                 wrEn,
  input  logic [AW-1:0]        wrAddr,
  input  logic                 srchEn,
  output cam_pkg::camCtrl_t    ctrl,
  output logic [ROWS-1:0]      rowSel
);
  always_comb begin
    ctrl.wrStb   = wrEn;
    ctrl.srchStb = srchEn;
  end

  // one-hot row decode; an index beyond ROWS selects nothing
  genvar r;
  generate
    for (r = 0; r < ROWS; r++) begin : g_dec
      assign rowSel[r] = wrEn && (wrAddr == AW'(r));
    end
  endgenerate
endmodule

// File: rtl/cam_datapath.sv
module cam_datapath #(
  parameter int ROWS   = 8,
  parameter int KEY_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cam_pkg::camCtrl_t    ctrl,
  input  logic [ROWS-1:0]      rowSel,
  input  logic [KEY_W-1:0]     wrKey,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 wrValid,
  input  logic [KEY_W-1:0]     srchKey,
  output logic                 hit,
  output logic [DATA_W-1:0]    rdData,
  output logic [ROWS-1:0]      matchVec,
  output logic [ROWS-1:0]      grantVec,
  output logic [ROWS-1:0]      validVec
);
  logic [KEY_W-1:0]  keyQ  [ROWS];
  logic [DATA_W-1:0] dataQ [ROWS];
  logic [ROWS-1:0]   validQ;
  logic [DATA_W-1:0] selData;
  logic              anyMatch;

  // storage: valid bits reset, payload does not need it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
    end else if (ctrl.wrStb) begin
      for (int r = 0; r < ROWS; r++) begin
        if (rowSel[r]) validQ[r] <= wrValid;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.wrStb) begin
      for (int r = 0; r < ROWS; r++) begin
        if (rowSel[r]) begin
          keyQ[r]  <= wrKey;
          dataQ[r] <= wrData;
        end
      end
    end
  end

  assign validVec = validQ;

  // per-row match line: NOR of bitwise mismatches, gated by valid
  genvar g;
  generate
    for (g = 0; g < ROWS; g++) begin : g_row
      logic [KEY_W-1:0] missBits;
      assign missBits    = keyQ[g] ^ srchKey;
      assign matchVec[g] = validQ[g] & ~(|missBits);
    end
  endgenerate

  // fixed priority: lowest matching row owns the data select
  always_comb begin
    logic taken;
    taken = 1'b0;
    for (int r = 0; r < ROWS; r++) begin
      grantVec[r] = matchVec[r] & ~taken;
      taken       = taken | matchVec[r];
    end
  end

  // select lines act as word lines: wired-OR of the granted word
  always_comb begin
    selData = '0;
    for (int r = 0; r < ROWS; r++) begin
      selData = selData | ({DATA_W{grantVec[r]}} & dataQ[r]);
    end
  end

  assign anyMatch = |matchVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hit    <= 1'b0;
      rdData <= '0;
    end else if (ctrl.srchStb) begin
      hit    <= anyMatch;
      rdData <= selData;
    end
  end
endmodule

// File: rtl/cam_lookup.sv
module cam_lookup #(
  parameter int ROWS   = 8,
  parameter int KEY_W  = 8,
  parameter int DATA_W = 16,
  localparam int AW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [KEY_W-1:0]  wrKey,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrValid,
  input  logic              srchEn,
  input  logic [KEY_W-1:0]  srchKey,
  output logic              hit,
  output logic [DATA_W-1:0] rdData
);
  cam_pkg::camCtrl_t ctrl;
  logic [ROWS-1:0]   rowSel;
  logic [ROWS-1:0]   matchVec;
  logic [ROWS-1:0]   grantVec;
  logic [ROWS-1:0]   validVec;

  cam_ctrl #(.ROWS(ROWS)) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .srchEn(srchEn),
    .ctrl(ctrl), .rowSel(rowSel)
  );

  cam_datapath #(.ROWS(ROWS), .KEY_W(KEY_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .rowSel(rowSel),
    .wrKey(wrKey), .wrData(wrData), .wrValid(wrValid), .srchKey(srchKey),
    .hit(hit), .rdData(rdData),
    .matchVec(matchVec), .grantVec(grantVec), .validVec(validVec)
  );
endmodule

// File: rtl/cam_checks.sv
module cam_checks #(
  parameter int ROWS   = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              srchEn,
  input logic              hit,
  input logic [DATA_W-1:0] rdData,
  input logic [ROWS-1:0]   matchVec,
  input logic [ROWS-1:0]   grantVec,
  input logic [ROWS-1:0]   validVec
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !srchEn |=> ($stable(hit) && $stable(rdData)));

  assert_miss_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (rdData == '0));

  assert_hit_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    srchEn |=> (hit == $past(|matchVec)));

  assert_invalid_silent_R3: assert property (@(posedge clk) disable iff (!rstN)
    (matchVec & ~validVec) == '0);

  assert_single_grant_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec) && ((grantVec & ~matchVec) == '0) &&
    ((matchVec == '0) || (grantVec != '0)));

  assert_lowest_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((grantVec - ROWS'(1)) & matchVec & ~grantVec) == '0 || grantVec == '0);
endmodule

bind cam_lookup cam_checks #(.ROWS(ROWS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .srchEn(srchEn), .hit(hit), .rdData(rdData),
  .matchVec(matchVec), .grantVec(grantVec), .validVec(validVec)
);

// File: tb/sim_cam_lookup.sv
`timescale 1ns/1ps
module sim_cam_lookup;
  localparam int ROWS = 8, KEY_W = 4, DATA_W = 8, AW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 0, wrValid = 0, srchEn = 0;
  logic [AW-1:0] wrAddr = '0;
  logic [KEY_W-1:0] wrKey = '0, srchKey = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic hit;
  logic [DATA_W-1:0] rdData;

  int checks = 0, fails = 0;

  logic [KEY_W-1:0]  mKey  [ROWS];
  logic [DATA_W-1:0] mData [ROWS];
  logic              mValid[ROWS];

  always #2.5 clk = ~clk;

  cam_lookup #(.ROWS(ROWS), .KEY_W(KEY_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrKey(wrKey),
    .wrData(wrData), .wrValid(wrValid), .srchEn(srchEn), .srchKey(srchKey),
    .hit(hit), .rdData(rdData)
  );

  function automatic logic [DATA_W:0] modelLookup(logic [KEY_W-1:0] k);
    for (int r = 0; r < ROWS; r++)
      if (mValid[r] && mKey[r] == k) return {1'b1, mData[r]};
    return '0;
  endfunction

  task automatic chk(string req, logic [DATA_W:0] exp);
    checks++;
    if ({hit, rdData} !== exp) begin
      fails++;
      $display("FAIL %s got hit=%0b data=%0h expected hit=%0b data=%0h",
               req, hit, rdData, exp[DATA_W], exp[DATA_W-1:0]);
    end
  endtask

  task automatic doWrite(int row, logic [KEY_W-1:0] k, logic [DATA_W-1:0] d, logic v);
    @(negedge clk);
    wrEn = 1; wrAddr = AW'(row); wrKey = k; wrData = d; wrValid = v;
    @(negedge clk);
    wrEn = 0;
    mKey[row] = k; mData[row] = d; mValid[row] = v;
  endtask

  task automatic doSearch(string req, logic [KEY_W-1:0] k);
    logic [DATA_W:0] exp;
    exp = modelLookup(k);
    @(negedge clk);
    srchEn = 1; srchKey = k;
    @(negedge clk);
    srchEn = 0;
    chk(req, exp);
  endtask

  task automatic sweep(string req);
    for (int k = 0; k < (1 << KEY_W); k++) doSearch(req, KEY_W'(k));
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired got running expected done");
    finishRun();
  end

  initial begin
    logic [DATA_W:0] held;
    for (int r = 0; r < ROWS; r++) begin mKey[r] = '0; mData[r] = '0; mValid[r] = 0; end
    repeat (3) @(negedge clk);
    chk("R8 reset outputs", '0);
    rstN = 1;
    doSearch("R8 empty table miss", 4'd0);
    doSearch("R8 empty table miss", 4'd15);

    // R1 R2 R5 R9: distinct keys, full sweep
    for (int r = 0; r < ROWS; r++) doWrite(r, KEY_W'(r*3+1), DATA_W'(8'hA0 + r), 1);
    sweep("R1 R2 R5 R9 sweep");

    // R4: duplicate key in rows 2 and 5
    doWrite(5, 4'd7, 8'h55, 1);
    doSearch("R4 lowest index", 4'd7);
    doWrite(2, 4'd7, 8'h22, 0);
    doSearch("R3 invalid row skipped", 4'd7);
    doSearch("R3 R4 other row intact", 4'd4);

    // R6: write and search on the same edge
    @(negedge clk);
    wrEn = 1; wrAddr = 0; wrKey = 4'd9; wrData = 8'h99; wrValid = 1;
    srchEn = 1; srchKey = 4'd9;
    held = modelLookup(4'd9);
    @(negedge clk);
    wrEn = 0; srchEn = 0;
    mKey[0] = 4'd9; mData[0] = 8'h99; mValid[0] = 1;
    chk("R6 same-edge search sees old", held);
    doSearch("R6 next search sees write", 4'd9);
    doSearch("R6 old key gone", 4'd1);

    // R7: hold with strobe low
    doSearch("R7 setup", 4'd10);
    held = modelLookup(4'd10);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      srchKey = KEY_W'(i * 5);
      chk("R7 hold", held);
    end

    // second loading, one row invalid, full sweep
    for (int r = 0; r < ROWS; r++) doWrite(r, KEY_W'(r*5+2), DATA_W'(r*17), r != 3);
    sweep("R1 R3 R5 second sweep");

    // R4 R9: stack one key in all rows, peel from the bottom
    for (int r = 0; r < ROWS; r++) doWrite(r, 4'd8, DATA_W'(8'h30 + r), 1);
    for (int r = 0; r < ROWS; r++) begin
      doSearch("R4 R9 peel", 4'd8);
      doWrite(r, 4'd8, 8'h00, 0);
    end
    doSearch("R3 all peeled miss", 4'd8);

    // R8: reset clears entries
    doWrite(6, 4'd3, 8'h66, 1);
    doSearch("R8 pre-reset hit", 4'd3);
    @(negedge clk);
    rstN = 0;
    @(negedge clk);
    chk("R8 outputs cleared", '0);
    rstN = 1;
    for (int r = 0; r < ROWS; r++) mValid[r] = 0;
    doSearch("R8 entries cleared", 4'd3);

    finishRun();
  end
endmodule